// File: doc/BRIEF.md
# Programmable Parallel Bus Master

This block is a synchronous master for an external asynchronous-memory-style parallel bus, of the kind used by NOR flash, SRAM, or simple memory-mapped peripherals. An internal client hands it one read or write at a time over a valid/ready request port. The block then runs a complete external cycle and returns a single response pulse, which carries the read data on reads. Each cycle can select one of eight chip-select lines, and it drives an address-latch strobe, a read strobe and a write strobe. It also drives a dedicated address bus and a shared bus that can carry the address before the data. A ready input from the device completes the cycle.

The length of every bus phase comes from a configuration register. A programmed value N always lasts N+1 clock cycles. The same register also holds the polarity of every control signal, the data width (16 or 32 bits), the multiplexed address/data option, the choice of chip-select line, and an option where the device raises ready one cycle ahead of its data. Configuration is written through a load strobe, and a load is taken only while no bus cycle is in progress.

Top module: `pbus_master`

## Requirements
- R1: A cycle runs these phases in order: setup (setupLen+1 cycles), the multiplexed address phase when enabled (muxLen+1), the strobe (weLen+1 on writes, oeLen+1 on reads), the ready-blind wait (waitLen+1), ready polling, one capture cycle for early-ready reads, and the hold (holdLen+1).
- R2: After reset the configuration is: setup 4, mux 1, adv 1, write strobe 1, read strobe 1, hold 1, wait 3. Every polarity bit is 0 (active low), the chip select is line 0, the data width is 16 bits, the address is non-multiplexed, and ready comes together with data.
- R3: The selected chip-select line (index = csSel) is active from the end of setup through the last hold cycle. No other line is ever active.
- R4: On a read the read strobe is active for exactly oeLen+1 cycles and the write strobe never asserts. On a write the write strobe is active for exactly weLen+1 cycles and the read strobe never asserts.
- R5: In multiplexed mode the shared bus carries the address, with its output enable high, for muxLen+1 cycles. The address-latch strobe is active for the first min(advLen,muxLen)+1 of those cycles. In non-multiplexed mode there is no address phase and the strobe never asserts.
- R6: Ready is ignored during the wait phase. After the wait phase, ready is sampled every cycle until it is seen active.
- R7: With the early option clear, read data is captured in the cycle in which ready is active. With the option set, it is captured in the following cycle. Writes ignore the option.
- R8: In 16-bit mode only bits 15:0 are used. Read data bits 31:16 return zero, and bits 31:16 of the shared bus are driven zero. In 32-bit mode all 32 bits are used.
- R9: Each polarity bit selects active low when 0 and active high when 1. The bits are: ready, address strobe, read/write strobes (one bit for both), and chip select.
- R10: Each accepted request gives exactly one rspValid pulse, in the cycle after the last hold cycle. reqReady stays low from the accept edge until that cycle, so new requests are stalled.
- R11: A configuration load is taken only while reqReady is high. A load during a bus cycle is ignored.
- R12: busAddr holds the request address for the whole cycle. On writes the shared bus drives the write data, with its output enable high, from the strobe phase through the hold. On reads it is released outside the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration load strobe |
| cfgWide | input | 1 | 1 = 32-bit data, 0 = 16-bit |
| cfgMux | input | 1 | Multiplexed address/data mode |
| cfgRdyEarly | input | 1 | Ready leads read data by one cycle |
| cfgRdyHigh | input | 1 | Ready polarity (1 = active high) |
| cfgAdvHigh | input | 1 | Address strobe polarity |
| cfgStrbHigh | input | 1 | Read/write strobe polarity |
| cfgCsHigh | input | 1 | Chip-select polarity |
| cfgCsSel | input | 3 | Chip-select line index |
| cfgSetupLen | input | 8 | Setup phase length code |
| cfgMuxLen | input | 4 | Address phase length code |
| cfgAdvLen | input | 4 | Address strobe length code |
| cfgWeLen | input | 4 | Write strobe length code |
| cfgOeLen | input | 8 | Read strobe length code |
| cfgHoldLen | input | 4 | Hold phase length code |
| cfgWaitLen | input | 8 | Ready-blind wait length code |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Read data |
| busCs | output | 8 | Chip-select lines |
| busAdv | output | 1 | Address-latch strobe |
| busOe | output | 1 | Read strobe |
| busWe | output | 1 | Write strobe |
| busAddr | output | ADDR_W | Dedicated address bus |
| busAd | output | DATA_W | Shared address/data bus output value |
| busAdOe | output | 1 | Shared bus output enable |
| busDin | input | DATA_W | Shared bus input value |
| busRdy | input | 1 | Device ready |

## Verification
The bench builds the block with its default parameters: a 28-bit address (the full 256 MB window), a 32-bit data path, and eight chip-select lines. These defaults allow the bench to exercise the top address bit, all-ones addresses, both data widths against the same 32-bit bus, and the highest and lowest chip-select indices. Because the 8-bit length fields keep their full width, the bench can also run a cycle with setup, read strobe and wait all at 255. It can equally run one with every field at 0, and one with the 4-bit fields all at 15.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int LONG_W  = 8;
  localparam int SHORT_W = 4;
  localparam int CSSEL_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_STRB,
    ST_WAIT,
    ST_POLL,
    ST_CAPT,
    ST_HOLD
  } pbus_state_e;

  typedef struct packed {
    logic               wide;
    logic               mux;
    logic               rdyEarly;
    logic               rdyHigh;
    logic               advHigh;
    logic               strbHigh;
    logic               csHigh;
    logic [CSSEL_W-1:0] csSel;
    logic [LONG_W-1:0]  setupLen;
    logic [LONG_W-1:0]  oeLen;
    logic [LONG_W-1:0]  waitLen;
    logic [SHORT_W-1:0] muxLen;
    logic [SHORT_W-1:0] advLen;
    logic [SHORT_W-1:0] weLen;
    logic [SHORT_W-1:0] holdLen;
  } pbus_cfg_t;

  localparam pbus_cfg_t CFG_RESET = '{
    wide:     1'b0,
    mux:      1'b0,
    rdyEarly: 1'b0,
    rdyHigh:  1'b0,
    advHigh:  1'b0,
    strbHigh: 1'b0,
    csHigh:   1'b0,
    csSel:    '0,
    setupLen: LONG_W'(4),
    oeLen:    LONG_W'(1),
    waitLen:  LONG_W'(3),
    muxLen:   SHORT_W'(1),
    advLen:   SHORT_W'(1),
    weLen:    SHORT_W'(1),
    holdLen:  SHORT_W'(1)
  };

  typedef struct packed {
    logic busy;
    logic latch;
    logic csOn;
    logic advOn;
    logic oeOn;
    logic weOn;
    logic adrOnAd;
    logic datOnAd;
    logic capture;
  } pbus_strb_t;

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       busRdy,
  input  pbus_cfg_t  cfg,
  output logic       reqReady,
  output logic       rspValid,
  output pbus_strb_t strb
);

  pbus_state_e       state, stateNx;
  logic [LONG_W-1:0] cnt;
  logic [LONG_W-1:0] phaseLen;
  logic              phaseEnd;
  logic              isWrite;
  logic              rdyAct;

  always_comb rdyAct = cfg.rdyHigh ? busRdy : ~busRdy;

  always_comb begin
    phaseLen = '0;
    unique case (state)
      ST_SETUP: phaseLen = cfg.setupLen;
      ST_ADDR:  phaseLen = LONG_W'(cfg.muxLen);
      ST_STRB:  phaseLen = isWrite ? LONG_W'(cfg.weLen) : cfg.oeLen;
      ST_WAIT:  phaseLen = cfg.waitLen;
      ST_HOLD:  phaseLen = LONG_W'(cfg.holdLen);
      default:  phaseLen = '0;
    endcase
  end

  always_comb phaseEnd = (cnt == phaseLen);

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNx = ST_SETUP;
      ST_SETUP: if (phaseEnd) stateNx = cfg.mux ? ST_ADDR : ST_STRB;
      ST_ADDR:  if (phaseEnd) stateNx = ST_STRB;
      ST_STRB:  if (phaseEnd) stateNx = ST_WAIT;
      ST_WAIT:  if (phaseEnd) stateNx = ST_POLL;
      ST_POLL:  if (rdyAct) stateNx = (!isWrite && cfg.rdyEarly) ? ST_CAPT : ST_HOLD;
      ST_CAPT:  stateNx = ST_HOLD;
      ST_HOLD:  if (phaseEnd) stateNx = ST_IDLE;
      default:  stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      isWrite  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNx;
      cnt      <= (stateNx != state || state == ST_IDLE) ? '0 : cnt + LONG_W'(1);
      rspValid <= (state == ST_HOLD) && phaseEnd;
      if (state == ST_IDLE && reqValid) isWrite <= reqWrite;
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    strb.busy    = (state != ST_IDLE);
    strb.latch   = (state == ST_IDLE) && reqValid;
    strb.csOn    = (state != ST_IDLE) && (state != ST_SETUP);
    strb.advOn   = (state == ST_ADDR) && (cnt <= LONG_W'(cfg.advLen));
    strb.oeOn    = (state == ST_STRB) && !isWrite;
    strb.weOn    = (state == ST_STRB) && isWrite;
    strb.adrOnAd = (state == ST_ADDR);
    strb.datOnAd = isWrite && (state inside {ST_STRB, ST_WAIT, ST_POLL, ST_CAPT, ST_HOLD});
    strb.capture = !isWrite &&
                   (((state == ST_POLL) && rdyAct && !cfg.rdyEarly) || (state == ST_CAPT));
  end

  // R1: setup cannot end before its programmed count
  assert_setup_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && cnt != cfg.setupLen) |=> (state == ST_SETUP));

  // R1: hold is entered only after ready was seen
  assert_hold_entry_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state) != ST_HOLD) |->
      ($past(state) == ST_POLL || $past(state) == ST_CAPT));

  // R6: polling persists while ready is inactive
  assert_poll_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL && !rdyAct) |=> (state == ST_POLL));

  // R10: response is a single-cycle pulse
  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/pbus_dpath.sv
module pbus_dpath
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  localparam int NUM_CS = 1 << CSSEL_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  pbus_cfg_t         cfgIn,
  input  pbus_strb_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output pbus_cfg_t         cfg,
  output logic [DATA_W-1:0] rspRdata,
  output logic [NUM_CS-1:0] busCs,
  output logic              busAdv,
  output logic              busOe,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busAd,
  output logic              busAdOe
);

  pbus_cfg_t         cfgQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] addrExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= CFG_RESET;
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (cfgWe && !strb.busy) cfgQ <= cfgIn;
      if (strb.latch) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= busDin & lowMask;
    end
  end

  always_comb begin
    cfg     = cfgQ;
    lowMask = cfgQ.wide ? '1 : DATA_W'({HALF_W{1'b1}});
    addrExt = DATA_W'(addrQ);
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gCs
    assign busCs[g] = (strb.csOn && cfgQ.csSel == CSSEL_W'(g)) ? cfgQ.csHigh : ~cfgQ.csHigh;
  end

  always_comb begin
    busAdv   = cfgQ.advHigh  ? strb.advOn : ~strb.advOn;
    busOe    = cfgQ.strbHigh ? strb.oeOn  : ~strb.oeOn;
    busWe    = cfgQ.strbHigh ? strb.weOn  : ~strb.weOn;
    busAddr  = addrQ;
    busAdOe  = strb.adrOnAd | strb.datOnAd;
    busAd    = strb.adrOnAd ? (addrExt & lowMask) :
               strb.datOnAd ? (wdataQ & lowMask) : '0;
    rspRdata = rdataQ;
  end

  // R11: configuration stays frozen across a bus cycle
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(cfgQ));

  // R3: at most one chip-select line active
  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busCs ^ {NUM_CS{~cfgQ.csHigh}}));

  // R8: upper half of the shared bus is quiet in narrow mode
  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgQ.wide && busAdOe) |-> (busAd[DATA_W-1:HALF_W] == '0));

  // R4: read and write strobes never overlap
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.oeOn && strb.weOn));

endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  localparam int NUM_CS = 1 << CSSEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgWide,
  input  logic               cfgMux,
  input  logic               cfgRdyEarly,
  input  logic               cfgRdyHigh,
  input  logic               cfgAdvHigh,
  input  logic               cfgStrbHigh,
  input  logic               cfgCsHigh,
  input  logic [CSSEL_W-1:0] cfgCsSel,
  input  logic [LONG_W-1:0]  cfgSetupLen,
  input  logic [SHORT_W-1:0] cfgMuxLen,
  input  logic [SHORT_W-1:0] cfgAdvLen,
  input  logic [SHORT_W-1:0] cfgWeLen,
  input  logic [LONG_W-1:0]  cfgOeLen,
  input  logic [SHORT_W-1:0] cfgHoldLen,
  input  logic [LONG_W-1:0]  cfgWaitLen,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspRdata,
  output logic [NUM_CS-1:0]  busCs,
  output logic               busAdv,
  output logic               busOe,
  output logic               busWe,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busAd,
  output logic               busAdOe,
  input  logic [DATA_W-1:0]  busDin,
  input  logic               busRdy
);

  pbus_cfg_t  cfgIn;
  pbus_cfg_t  cfg;
  pbus_strb_t strb;

  always_comb begin
    cfgIn.wide     = cfgWide;
    cfgIn.mux      = cfgMux;
    cfgIn.rdyEarly = cfgRdyEarly;
    cfgIn.rdyHigh  = cfgRdyHigh;
    cfgIn.advHigh  = cfgAdvHigh;
    cfgIn.strbHigh = cfgStrbHigh;
    cfgIn.csHigh   = cfgCsHigh;
    cfgIn.csSel    = cfgCsSel;
    cfgIn.setupLen = cfgSetupLen;
    cfgIn.oeLen    = cfgOeLen;
    cfgIn.waitLen  = cfgWaitLen;
    cfgIn.muxLen   = cfgMuxLen;
    cfgIn.advLen   = cfgAdvLen;
    cfgIn.weLen    = cfgWeLen;
    cfgIn.holdLen  = cfgHoldLen;
  end

  pbus_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busRdy   (busRdy),
    .cfg      (cfg),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strb     (strb)
  );

  pbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgIn    (cfgIn),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busDin   (busDin),
    .cfg      (cfg),
    .rspRdata (rspRdata),
    .busCs    (busCs),
    .busAdv   (busAdv),
    .busOe    (busOe),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busAd    (busAd),
    .busAdOe  (busAdOe)
  );

endmodule

// File: tb/pbus_master_tb_top.sv
module pbus_master_tb_top;

  typedef struct packed {
    logic        write;
    logic        mux;
    logic        wide;
    logic        early;
    logic [3:0]  pol;      // [3] ready, [2] adv, [1] strobes, [0] cs
    logic [2:0]  csSel;
    logic [7:0]  setup;
    logic [3:0]  muxLen;
    logic [3:0]  advLen;
    logic [7:0]  strLen;
    logic [3:0]  hold;
    logic [7:0]  waitLen;
    logic [3:0]  gap;
    logic [27:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,1'b0,1'b0,1'b0,4'b0000,3'd0,8'd0,  4'd0, 4'd0, 8'd0,  4'd0, 8'd0,  4'd0,28'h0000123,32'hA5A51234},
    '{1'b1,1'b0,1'b1,1'b0,4'b1111,3'd7,8'd3,  4'd0, 4'd0, 8'd2,  4'd2, 8'd1,  4'd2,28'hFFFFFFF,32'hDEADBEEF},
    '{1'b0,1'b1,1'b1,1'b1,4'b0101,3'd3,8'd1,  4'd2, 4'd0, 8'd5,  4'd1, 8'd2,  4'd1,28'h8001234,32'h13579BDF},
    '{1'b1,1'b1,1'b0,1'b0,4'b1010,3'd5,8'd2,  4'd1, 4'd3, 8'd1,  4'd3, 8'd0,  4'd0,28'h0ABCDEF,32'hCAFEF00D},
    '{1'b0,1'b1,1'b0,1'b0,4'b0011,3'd1,8'd0,  4'd3, 4'd2, 8'd3,  4'd0, 8'd4,  4'd3,28'h1234567,32'hFFFF8001},
    '{1'b0,1'b0,1'b1,1'b1,4'b1000,3'd6,8'd255,4'd0, 4'd0, 8'd255,4'd0, 8'd255,4'd0,28'h5555555,32'h0F0F0F0F},
    '{1'b1,1'b1,1'b1,1'b0,4'b0000,3'd2,8'd0,  4'd15,4'd15,8'd15, 4'd15,8'd0,  4'd0,28'h7654321,32'h89ABCDEF},
    '{1'b1,1'b0,1'b0,1'b1,4'b0100,3'd4,8'd1,  4'd0, 4'd0, 8'd0,  4'd0, 8'd1,  4'd1,28'h0000002,32'h1234ABCD}
  };

  localparam vec_t DEF_RD = '{1'b0,1'b0,1'b0,1'b0,4'b0000,3'd0,8'd4,4'd1,4'd1,8'd1,4'd1,8'd3,4'd1,28'h0000ABC,32'h98765432};
  localparam vec_t DEF_WR = '{1'b1,1'b0,1'b0,1'b0,4'b0000,3'd0,8'd4,4'd1,4'd1,8'd1,4'd1,8'd3,4'd0,28'h00F00F0,32'h11223344};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgWide = 1'b0, cfgMux = 1'b0, cfgRdyEarly = 1'b0;
  logic        cfgRdyHigh = 1'b0, cfgAdvHigh = 1'b0, cfgStrbHigh = 1'b0, cfgCsHigh = 1'b0;
  logic [2:0]  cfgCsSel = '0;
  logic [7:0]  cfgSetupLen = 8'd4, cfgOeLen = 8'd1, cfgWaitLen = 8'd3;
  logic [3:0]  cfgMuxLen = 4'd1, cfgAdvLen = 4'd1, cfgWeLen = 4'd1, cfgHoldLen = 4'd1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [27:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic [31:0] rspRdata;
  logic [7:0]  busCs;
  logic        busAdv, busOe, busWe, busAdOe;
  logic [27:0] busAddr;
  logic [31:0] busAd;
  logic [31:0] busDin = '0;
  logic        busRdy = 1'b1;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pbus_master dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWide(cfgWide), .cfgMux(cfgMux),
    .cfgRdyEarly(cfgRdyEarly), .cfgRdyHigh(cfgRdyHigh), .cfgAdvHigh(cfgAdvHigh),
    .cfgStrbHigh(cfgStrbHigh), .cfgCsHigh(cfgCsHigh), .cfgCsSel(cfgCsSel),
    .cfgSetupLen(cfgSetupLen), .cfgMuxLen(cfgMuxLen), .cfgAdvLen(cfgAdvLen),
    .cfgWeLen(cfgWeLen), .cfgOeLen(cfgOeLen), .cfgHoldLen(cfgHoldLen), .cfgWaitLen(cfgWaitLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata), .busCs(busCs),
    .busAdv(busAdv), .busOe(busOe), .busWe(busWe), .busAddr(busAddr), .busAd(busAd),
    .busAdOe(busAdOe), .busDin(busDin), .busRdy(busRdy)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic setCfg(input vec_t v);
    cfgWide = v.wide; cfgMux = v.mux; cfgRdyEarly = v.early;
    cfgRdyHigh = v.pol[3]; cfgAdvHigh = v.pol[2]; cfgStrbHigh = v.pol[1]; cfgCsHigh = v.pol[0];
    cfgCsSel = v.csSel; cfgSetupLen = v.setup; cfgMuxLen = v.muxLen; cfgAdvLen = v.advLen;
    cfgWeLen = v.strLen[3:0]; cfgOeLen = v.strLen; cfgHoldLen = v.hold; cfgWaitLen = v.waitLen;
    cfgWe = 1'b1;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic runTxn(input vec_t v, input bit rdyAlways, input bit poke, input string tag);
    int str, muxPh, pollStart, readyCyc, capt, capCyc, total, n;
    int csCnt, wrongCs, oeCnt, weCnt, advCnt, adrCnt, datCnt, adOeCnt, rrCnt, addrCnt;
    int advExp;
    logic [31:0] mask, expAdrAd, expWd;
    bit done;
    mask      = v.wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    expAdrAd  = {4'h0, v.addr} & mask;
    expWd     = v.data & mask;
    str       = v.write ? int'(v.strLen[3:0]) : int'(v.strLen);
    muxPh     = v.mux ? int'(v.muxLen) + 1 : 0;
    pollStart = (int'(v.setup) + 1) + muxPh + (str + 1) + (int'(v.waitLen) + 1);
    readyCyc  = rdyAlways ? pollStart + 1 : pollStart + 1 + int'(v.gap);
    capt      = (!v.write && v.early) ? 1 : 0;
    capCyc    = readyCyc + capt;
    total     = readyCyc + capt + int'(v.hold) + 1;
    advExp    = v.mux ? ((v.advLen < v.muxLen) ? int'(v.advLen) : int'(v.muxLen)) + 1 : 0;
    csCnt = 0; wrongCs = 0; oeCnt = 0; weCnt = 0; advCnt = 0; adrCnt = 0;
    datCnt = 0; adOeCnt = 0; rrCnt = 0; addrCnt = 0;

    chk("R10", {tag, " ready before request"}, reqReady, 1);
    busRdy   = rdyAlways ? v.pol[3] : ~v.pol[3];
    reqValid = 1'b1; reqWrite = v.write; reqAddr = v.addr; reqWdata = v.data;
    @(posedge clk); #1;
    reqValid = 1'b0; reqWdata = ~v.data; reqAddr = ~v.addr;
    n = 0; done = 1'b0;
    while (!done) begin
      if (n > 0 && rspValid) done = 1'b1;
      else if (n > 4000) done = 1'b1;
      else begin
        busRdy = (rdyAlways || (n + 1) >= readyCyc) ? v.pol[3] : ~v.pol[3];
        busDin = ((n + 1) == capCyc) ? v.data : ~v.data;
        if (busCs[v.csSel] == v.pol[0]) csCnt++;
        for (int i = 0; i < 8; i++)
          if (i != int'(v.csSel) && busCs[i] == v.pol[0]) wrongCs++;
        if (busOe == v.pol[1]) oeCnt++;
        if (busWe == v.pol[1]) weCnt++;
        if (busAdv == v.pol[2]) advCnt++;
        if (busAdOe) adOeCnt++;
        if (busAdOe && busAd == expAdrAd) adrCnt++;
        if (busAdOe && busAd == expWd) datCnt++;
        if (reqReady) rrCnt++;
        if (busAddr == v.addr) addrCnt++;
        if (poke && n == 1) begin cfgWe = 1'b1; cfgSetupLen = 8'd200; end
        else cfgWe = 1'b0;
        @(posedge clk); #1;
        n++;
      end
    end
    cfgWe = 1'b0; cfgSetupLen = v.setup;
    busRdy = ~v.pol[3];

    chk("R1",  {tag, " cycle latency"}, n, total);
    chk("R10", {tag, " reqReady low while busy"}, rrCnt, 0);
    chk("R3",  {tag, " selected cs active cycles"}, csCnt, total - (int'(v.setup) + 1));
    chk("R3",  {tag, " other cs lines active"}, wrongCs, 0);
    chk("R4",  {tag, " read strobe cycles"}, oeCnt, v.write ? 0 : str + 1);
    chk("R4",  {tag, " write strobe cycles"}, weCnt, v.write ? str + 1 : 0);
    chk("R5",  {tag, " address strobe cycles"}, advCnt, advExp);
    chk("R5",  {tag, " address on shared bus"}, adrCnt, muxPh);
    chk("R12", {tag, " write data on shared bus"}, datCnt,
        v.write ? total - (int'(v.setup) + 1) - muxPh : 0);
    chk("R12", {tag, " shared bus enable cycles"}, adOeCnt,
        v.write ? total - (int'(v.setup) + 1) : muxPh);
    chk("R12", {tag, " address pins held"}, addrCnt, total);
    if (!v.write) chk("R7", {tag, " read data (R8 masking)"}, rspRdata, v.data & mask);
    @(posedge clk); #1;
    chk("R10", {tag, " single response pulse"}, rspValid, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    busRdy = 1'b1;
    // R2 / R9: reset state, all outputs at inactive-low levels
    chk("R2", "reset reqReady", reqReady, 1);
    chk("R2", "reset rspValid", rspValid, 0);
    chk("R9", "reset cs lines idle high", busCs, 8'hFF);
    chk("R9", "reset strobes idle high", {busAdv, busOe, busWe}, 3'b111);
    chk("R12", "reset shared bus released", busAdOe, 0);

    // R2: reset configuration without any load
    runTxn(DEF_RD, 1'b0, 1'b0, "default read");
    runTxn(DEF_WR, 1'b0, 1'b0, "default write");

    // vector table
    for (int i = 0; i < NV; i++) begin
      setCfg(VECS[i]);
      runTxn(VECS[i], 1'b0, 1'b0, $sformatf("vec%0d", i));
    end

    // R6: ready held active during the wait phase is ignored
    setCfg(VECS[2]);
    runTxn(VECS[2], 1'b1, 1'b0, "R6 ready early held");
    setCfg(VECS[4]);
    runTxn(VECS[4], 1'b1, 1'b0, "R6 ready held narrow");

    // R11: config load during a cycle is ignored (first and following cycle)
    setCfg(VECS[1]);
    runTxn(VECS[1], 1'b0, 1'b1, "R11 poke");
    runTxn(VECS[1], 1'b0, 1'b0, "R11 after poke");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule